// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two data ports, A and B, in both directions. Each direction owns a storage register and a source select. When the select is low, the side being driven receives the live value from the opposite port. When the select is high, it receives that direction's stored word. Each register loads from its source port on the rising edge of its own load strobe. Loading ignores the output enables and the selects.

The datapath is split into independent halves. Each half has its own six controls: two enables, two selects and two load strobes. The halves can run as separate narrow transceivers or together as one wide transceiver. Each port is modelled as three vectors: an input vector carrying the resolved level on the wire, a data output vector and a per-bit output-enable vector. The A-to-B enable is active high and the B-to-A enable is active low.

All logic runs on one free-running system clock. Each load strobe passes through a synchroniser and an edge detector. Each port's data and output enable are registered together, so the selected data and the enable change on the same clock edge.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every bit of `a_oe`, `a_out`, `b_oe` and `b_out` is 0. Both storage registers of every half reset to zero.
- R2: The B-side enable is active high. One clock after `ab_oe[h]` is sampled as 1, all `b_oe` bits of half h are 1. One clock after it is sampled as 0, they are 0.
- R3: The A-side enable is active low. One clock after `ba_oe_n[h]` is sampled as 0, all `a_oe` bits of half h are 1. One clock after it is sampled as 1, they are 0.
- R4: When `ab_sel[h]` is 0 (live), the `b_out` slice of half h equals the `a_in` slice of the previous clock. When `ba_sel[h]` is 0, the `a_out` slice equals the previous `b_in` slice. The data outputs follow this rule whether or not they are enabled.
- R5: When `ab_sel[h]` is 1 (stored), `b_out` of half h carries the A-to-B register. When `ba_sel[h]` is 1, `a_out` carries the B-to-A register.
- R6: A rising edge on `ab_ld[h]` loads the A-to-B register from `a_in`, and a rising edge on `ba_ld[h]` loads the B-to-A register from `b_in`. The load happens whatever the levels of the enables and selects, including when neither port drives (`ab_oe`=0, `ba_oe_n`=1). The value captured is the source port value at the third system clock edge after the strobe rises.
- R7: Holding a load strobe high loads its register once. A later change on the source port, while the strobe stays high, leaves the stored word unchanged.
- R8: Half h occupies data bits [h*HALF_W +: HALF_W]. Controls of one half never change the registers or outputs of another half.
- R9: With `ab_oe`=1, `ba_oe_n`=0 and both selects at 1, both ports are driven at the same time: B with the A-to-B register and A with the B-to-A register.
- R10: With `ab_oe`=1 and `ab_sel`=1, B carries the A-to-B word. A `ba_ld` edge then captures that word, so both registers hold the A-to-B word.
- R11: With both directions enabled and both selects at 0, each port keeps the value it held, and changes from outside sources on either port have no effect.
- R12: When a select changes while its output is enabled, the data output moves from the old source to the new source in exactly one clock and never shows any other value in between. The output enable stays steady throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_oe | input | N_HALF | Per-half A-to-B output enable, active high |
| ba_oe_n | input | N_HALF | Per-half B-to-A output enable, active low |
| ab_sel | input | N_HALF | Per-half B-side source: 0 live A, 1 stored |
| ba_sel | input | N_HALF | Per-half A-side source: 0 live B, 1 stored |
| ab_ld | input | N_HALF | Per-half load strobe of the A-to-B register (asynchronous) |
| ba_ld | input | N_HALF | Per-half load strobe of the B-to-A register (asynchronous) |
| a_in | input | N_HALF*HALF_W | Resolved level on the A wires |
| a_out | output | N_HALF*HALF_W | Data driven toward A |
| a_oe | output | N_HALF*HALF_W | Per-bit drive enable toward A |
| b_in | input | N_HALF*HALF_W | Resolved level on the B wires |
| b_out | output | N_HALF*HALF_W | Data driven toward B |
| b_oe | output | N_HALF*HALF_W | Per-bit drive enable toward B |

## Verification
The bench resolves both buses, so the design's own outputs feed back into its inputs. This is what makes the store-A-in-both loop and the hold-last-value behaviour observable. A design with the B-to-A enable polarity inverted would drive A in isolation mode, and the enable checks would catch it. A design whose loads were gated by the enables would leave the register unchanged when a load happens while both ports are isolated. A design that sensed the strobe level rather than its edge would reload while the strobe is held high, and the held value would differ. A design that registered the data but not the enable, or the reverse, would show a misaligned cycle when the select toggles. The glitch check compares every cycle of that switch.

// File: rtl/xcvr_pkg.sv
// Package: shared types and constants of the registered bus transceiver.
// Assumes: the consumers use the select encoding below on their pins.
package xcvr_pkg;

    // Default depth of the load-strobe synchroniser
    localparam int unsigned XCVR_SYNC_DEPTH = 2;

    // Source choice of one direction's drive stage
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

endpackage

// File: rtl/xcvr_edge_pulse.sv
// Module: xcvr_edge_pulse
// Brings an asynchronous load strobe into the clk domain and produces a
// one-cycle pulse on each of its rising edges.
// Assumes: each strobe level lasts at least two clk periods.
module xcvr_edge_pulse #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic pulse_o
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0] sync_q;
    logic             prev_q;

    // Synchroniser chain: stage 0 samples the asynchronous strobe
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= strobe_i;
    end

    genvar s;
    generate
        for (s = 1; s < DEPTH; s++) begin : g_stage
            // Each later stage retimes the one before
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronised level, used to find the edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Rising edge detected
    assign pulse_o = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/xcvr_store_reg.sv
// Module: xcvr_store_reg
// Storage register of one direction. It captures its source port when the
// load pulse is high, whatever the output controls are doing.
// Assumes: load_i is a single-cycle pulse in the clk domain.
module xcvr_store_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] word_q;

    // Capture the source port value on a load pulse
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= d_i;
    end

    assign q_o = word_q;

endmodule

// File: rtl/xcvr_drive_stage.sv
// Module: xcvr_drive_stage
// Output stage of one direction. It picks the live or the stored word and
// registers that word together with the per-bit enable, so both change
// on the same clk edge.
// Assumes: en_i is already in active-high form.
module xcvr_drive_stage #(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  xcvr_pkg::src_sel_e sel_i,
    input  logic [W-1:0]      live_i,
    input  logic [W-1:0]      stored_i,
    output logic [W-1:0]      data_o,
    output logic [W-1:0]      oe_o
);
    import xcvr_pkg::*;

    logic [W-1:0] pick;
    logic [W-1:0] data_q;
    logic [W-1:0] oe_q;

    // Source multiplexer ahead of the output register
    always_comb begin
        pick = (sel_i == SRC_STORED) ? stored_i : live_i;
    end

    // Register the data and the enable together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oe_q   <= '0;
        end else begin
            data_q <= pick;
            oe_q   <= {W{en_i}};
        end
    end

    assign data_o = data_q;
    assign oe_o   = oe_q;

endmodule

// File: rtl/xcvr_half.sv
// Module: xcvr_half
// One independent half of the transceiver. It holds both directions'
// strobe detectors, storage registers and drive stages.
// Assumes: a_i and b_i are the resolved wire levels, including this
// half's own drive.
module xcvr_half #(
    parameter int unsigned W          = 8,
    parameter int unsigned SYNC_DEPTH = xcvr_pkg::XCVR_SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_en_i,
    input  logic         ba_en_n_i,
    input  logic         ab_sel_i,
    input  logic         ba_sel_i,
    input  logic         ab_ld_i,
    input  logic         ba_ld_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] a_oe_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] b_oe_o
);
    import xcvr_pkg::*;

    logic         ab_load, ba_load;
    logic [W-1:0] ab_word, ba_word;
    src_sel_e     ab_src, ba_src;

    // Map the raw select pins onto the source type
    always_comb begin
        ab_src = ab_sel_i ? SRC_STORED : SRC_LIVE;
        ba_src = ba_sel_i ? SRC_STORED : SRC_LIVE;
    end

    xcvr_edge_pulse #(.DEPTH(SYNC_DEPTH)) i_ab_edge (
        .clk(clk), .rst_n(rst_n), .strobe_i(ab_ld_i), .pulse_o(ab_load)
    );
    xcvr_edge_pulse #(.DEPTH(SYNC_DEPTH)) i_ba_edge (
        .clk(clk), .rst_n(rst_n), .strobe_i(ba_ld_i), .pulse_o(ba_load)
    );

    xcvr_store_reg #(.W(W)) i_ab_reg (
        .clk(clk), .rst_n(rst_n), .load_i(ab_load), .d_i(a_i), .q_o(ab_word)
    );
    xcvr_store_reg #(.W(W)) i_ba_reg (
        .clk(clk), .rst_n(rst_n), .load_i(ba_load), .d_i(b_i), .q_o(ba_word)
    );

    // Toward B: the enable pin is active high
    xcvr_drive_stage #(.W(W)) i_b_drive (
        .clk(clk), .rst_n(rst_n), .en_i(ab_en_i), .sel_i(ab_src),
        .live_i(a_i), .stored_i(ab_word), .data_o(b_o), .oe_o(b_oe_o)
    );
    // Toward A: the enable pin is active low
    xcvr_drive_stage #(.W(W)) i_a_drive (
        .clk(clk), .rst_n(rst_n), .en_i(~ba_en_n_i), .sel_i(ba_src),
        .live_i(b_i), .stored_i(ba_word), .data_o(a_o), .oe_o(a_oe_o)
    );

endmodule

// File: rtl/dual_reg_xcvr.sv
// Module: dual_reg_xcvr (top)
// Registered bidirectional transceiver made of N_HALF independent halves
// of HALF_W bits each. Every port is split into input, output and
// per-bit enable vectors.
// Assumes: the enables and selects are synchronous to clk. The load
// strobes may be asynchronous.
module dual_reg_xcvr #(
    parameter int unsigned HALF_W     = 8,
    parameter int unsigned N_HALF     = 2,
    parameter int unsigned SYNC_DEPTH = xcvr_pkg::XCVR_SYNC_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_HALF-1:0]          ab_oe,
    input  logic [N_HALF-1:0]          ba_oe_n,
    input  logic [N_HALF-1:0]          ab_sel,
    input  logic [N_HALF-1:0]          ba_sel,
    input  logic [N_HALF-1:0]          ab_ld,
    input  logic [N_HALF-1:0]          ba_ld,
    input  logic [N_HALF*HALF_W-1:0]   a_in,
    output logic [N_HALF*HALF_W-1:0]   a_out,
    output logic [N_HALF*HALF_W-1:0]   a_oe,
    input  logic [N_HALF*HALF_W-1:0]   b_in,
    output logic [N_HALF*HALF_W-1:0]   b_out,
    output logic [N_HALF*HALF_W-1:0]   b_oe
);
    genvar h;
    generate
        for (h = 0; h < N_HALF; h++) begin : g_half
            localparam int unsigned LO = h * HALF_W;
            xcvr_half #(.W(HALF_W), .SYNC_DEPTH(SYNC_DEPTH)) i_half (
                .clk       (clk),
                .rst_n     (rst_n),
                .ab_en_i   (ab_oe[h]),
                .ba_en_n_i (ba_oe_n[h]),
                .ab_sel_i  (ab_sel[h]),
                .ba_sel_i  (ba_sel[h]),
                .ab_ld_i   (ab_ld[h]),
                .ba_ld_i   (ba_ld[h]),
                .a_i       (a_in[LO +: HALF_W]),
                .b_i       (b_in[LO +: HALF_W]),
                .a_o       (a_out[LO +: HALF_W]),
                .a_oe_o    (a_oe[LO +: HALF_W]),
                .b_o       (b_out[LO +: HALF_W]),
                .b_oe_o    (b_oe[LO +: HALF_W])
            );
        end
    endgenerate

endmodule

// File: rtl/xcvr_chk.sv
// Module: xcvr_chk
// Checker bound to dual_reg_xcvr. It relates the top-level ports over time.
module xcvr_chk #(
    parameter int unsigned HALF_W = 8,
    parameter int unsigned N_HALF = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_HALF-1:0]        ab_oe,
    input logic [N_HALF-1:0]        ba_oe_n,
    input logic [N_HALF-1:0]        ab_sel,
    input logic [N_HALF-1:0]        ba_sel,
    input logic [N_HALF*HALF_W-1:0] a_in,
    input logic [N_HALF*HALF_W-1:0] b_in,
    input logic [N_HALF*HALF_W-1:0] a_out,
    input logic [N_HALF*HALF_W-1:0] a_oe,
    input logic [N_HALF*HALF_W-1:0] b_out,
    input logic [N_HALF*HALF_W-1:0] b_oe
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    genvar h;
    generate
        for (h = 0; h < N_HALF; h++) begin : g_chk
            localparam int unsigned LO = h * HALF_W;
            // R2
            b_en_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (b_oe[LO +: HALF_W] == {HALF_W{$past(ab_oe[h])}}));
            // R3
            a_en_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (a_oe[LO +: HALF_W] == {HALF_W{~$past(ba_oe_n[h])}}));
            // R4
            b_live_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(ab_sel[h])) |-> (b_out[LO +: HALF_W] == $past(a_in[LO +: HALF_W])));
            // R4
            a_live_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(ba_sel[h])) |-> (a_out[LO +: HALF_W] == $past(b_in[LO +: HALF_W])));
            // R11
            live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(ab_oe[h]) && !$past(ba_oe_n[h]) && !$past(ab_sel[h])
                 && !$past(ba_sel[h]) && a_oe[LO +: HALF_W] == {HALF_W{1'b1}}
                 && b_oe[LO +: HALF_W] == {HALF_W{1'b1}})
                |=> ($past(ab_oe[h]) && !$past(ba_oe_n[h]) && !$past(ab_sel[h]) && !$past(ba_sel[h]))
                    |-> $stable(a_out[LO +: HALF_W]));
        end
    endgenerate
endmodule

bind dual_reg_xcvr xcvr_chk #(.HALF_W(HALF_W), .N_HALF(N_HALF)) i_xcvr_chk (
    .clk(clk), .rst_n(rst_n), .ab_oe(ab_oe), .ba_oe_n(ba_oe_n),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/test_dual_reg_xcvr.sv
// Scoreboard bench: driver tasks push expected port states, a monitor
// pops and compares them at the falling edge.
module test_dual_reg_xcvr;
    localparam int HW = 8;
    localparam int NH = 2;
    localparam int W  = HW * NH;

    typedef struct {
        string        tag;
        logic [W-1:0] a_out, a_oe, b_out, b_oe;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NH-1:0] ab_oe = '0, ba_oe_n = '1, ab_sel = '0, ba_sel = '0;
    logic [NH-1:0] ab_ld = '0, ba_ld = '0;
    logic [W-1:0]  a_in, b_in, a_out, a_oe, b_out, b_oe;
    logic [HW-1:0] a_ext [NH];
    logic [HW-1:0] b_ext [NH];
    logic [HW-1:0] m_ab [NH];
    logic [HW-1:0] m_ba [NH];
    logic [HW-1:0] hold [NH];
    logic [W-1:0]  a_ext_f, b_ext_f;
    item_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign a_ext_f = {a_ext[1], a_ext[0]};
    assign b_ext_f = {b_ext[1], b_ext[0]};
    // Resolved bus: driven bits take the design's output
    assign a_in = (a_oe & a_out) | (~a_oe & a_ext_f);
    assign b_in = (b_oe & b_out) | (~b_oe & b_ext_f);

    dual_reg_xcvr #(.HALF_W(HW), .N_HALF(NH)) i_dual_reg_xcvr (
        .clk(clk), .rst_n(rst_n), .ab_oe(ab_oe), .ba_oe_n(ba_oe_n),
        .ab_sel(ab_sel), .ba_sel(ba_sel), .ab_ld(ab_ld), .ba_ld(ba_ld),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Model of the settled bus levels of one half
    task automatic resolve(input int h, output logic [HW-1:0] abus, output logic [HW-1:0] bbus);
        logic a_drv, b_drv;
        a_drv = !ba_oe_n[h];
        b_drv = ab_oe[h];
        if (a_drv && b_drv && !ab_sel[h] && !ba_sel[h]) begin
            abus = hold[h];
            bbus = hold[h];
        end else begin
            abus = a_ext[h];
            bbus = b_ext[h];
            if (a_drv && ba_sel[h]) abus = m_ba[h];
            if (b_drv && ab_sel[h]) bbus = m_ab[h];
            if (a_drv && !ba_sel[h]) abus = bbus;
            if (b_drv && !ab_sel[h]) bbus = abus;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Driver: push the expected port state, then let the monitor pop it
    task automatic expect_now(input string tag);
        item_t it;
        logic [HW-1:0] ab, bb;
        it.tag = tag;
        for (int h = 0; h < NH; h++) begin
            resolve(h, ab, bb);
            it.a_oe[h*HW +: HW]  = {HW{!ba_oe_n[h]}};
            it.b_oe[h*HW +: HW]  = {HW{ab_oe[h]}};
            it.a_out[h*HW +: HW] = ba_sel[h] ? m_ba[h] : bb;
            it.b_out[h*HW +: HW] = ab_sel[h] ? m_ab[h] : ab;
        end
        q.push_back(it);
        settle(1);
    endtask

    // Raise a load strobe, update the model from the source port, release
    task automatic load(input int h, input bit to_b);
        logic [HW-1:0] ab, bb;
        if (to_b) ab_ld[h] = 1'b1; else ba_ld[h] = 1'b1;
        settle(5);
        resolve(h, ab, bb);
        if (to_b) m_ab[h] = ab; else m_ba[h] = bb;
        if (to_b) ab_ld[h] = 1'b0; else ba_ld[h] = 1'b0;
        settle(4);
    endtask

    // Monitor: compare the design's ports against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (a_out !== it.a_out || a_oe !== it.a_oe || b_out !== it.b_out || b_oe !== it.b_oe) begin
                    n_fail++;
                    $display("FAIL %s: a_out=%h a_oe=%h b_out=%h b_oe=%h exp a_out=%h a_oe=%h b_out=%h b_oe=%h",
                             it.tag, a_out, a_oe, b_out, b_oe, it.a_out, it.a_oe, it.b_out, it.b_oe);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        item_t rz;
        for (int h = 0; h < NH; h++) begin
            a_ext[h] = '0; b_ext[h] = '0; m_ab[h] = '0; m_ba[h] = '0; hold[h] = '0;
        end
        settle(3);
        // R1: all outputs quiet during reset
        rz.tag = "R1 reset"; rz.a_out = '0; rz.a_oe = '0; rz.b_out = '0; rz.b_oe = '0;
        q.push_back(rz);
        settle(1);
        rst_n = 1'b1;
        settle(2);
        // R1: registers are zero, observed through the stored select
        ab_sel = '1; ba_sel = '1;
        settle(2);
        expect_now("R1 registers zero");

        // R6: load both registers of half 0 while isolated
        ab_sel = '0; ba_sel = '0;
        a_ext[0] = 8'h5A; b_ext[0] = 8'hC3; a_ext[1] = 8'h11; b_ext[1] = 8'h22;
        settle(2);
        expect_now("R4 isolated live view");
        ab_ld[0] = 1'b1; ba_ld[0] = 1'b1;
        settle(5);
        m_ab[0] = 8'h5A; m_ba[0] = 8'hC3;
        ab_ld[0] = 1'b0; ba_ld[0] = 1'b0;
        settle(4);
        a_ext[0] = 8'h00; b_ext[0] = 8'hFF;
        ab_sel[0] = 1'b1; ba_sel[0] = 1'b1;
        settle(2);
        expect_now("R6 isolated load, R5 stored view");

        // R8: half 1 registers untouched by half 0 loads
        ab_sel[1] = 1'b1; ba_sel[1] = 1'b1;
        settle(2);
        expect_now("R8 half1 unchanged");
        load(1, 1'b1);
        ab_sel[1] = 1'b1;
        settle(2);
        expect_now("R8 half1 load, half0 intact");

        // R2: A-to-B enable is active high
        ab_sel[0] = 1'b0; ab_oe[0] = 1'b1; a_ext[0] = 8'h3C;
        settle(2);
        expect_now("R2 b_oe on, R4 live A to B");
        a_ext[0] = 8'hA7;
        settle(2);
        expect_now("R4 live follows A");
        ab_oe[0] = 1'b0;
        settle(2);
        expect_now("R2 b_oe off");

        // R3: B-to-A enable is active low
        ba_sel[0] = 1'b0; ba_oe_n[0] = 1'b0; b_ext[0] = 8'h96;
        settle(2);
        expect_now("R3 a_oe on, R4 live B to A");
        ba_oe_n[0] = 1'b1;
        settle(2);
        expect_now("R3 a_oe off");

        // R9: both directions drive stored words
        ab_oe[0] = 1'b1; ba_oe_n[0] = 1'b0; ab_sel[0] = 1'b1; ba_sel[0] = 1'b1;
        settle(2);
        expect_now("R9 both stored");

        // R12: toggle a select with the output enabled, every cycle compared
        ab_sel[0] = 1'b0;
        expect_now("R12 switch to live c1");
        expect_now("R12 switch to live c2");
        ab_sel[0] = 1'b1;
        expect_now("R12 switch to stored c1");
        expect_now("R12 switch to stored c2");

        // R10: store the A word in both registers through B
        ba_oe_n[0] = 1'b1;
        settle(2);
        load(0, 1'b0);
        ba_oe_n[0] = 1'b0; ba_sel[0] = 1'b1;
        settle(2);
        if (m_ba[0] !== m_ab[0]) begin
            n_fail++;
            $display("FAIL R10 model: m_ba=%h exp=%h", m_ba[0], m_ab[0]);
        end
        expect_now("R10 A word in both registers");

        // R7: strobe held high loads once
        ab_oe[0] = 1'b0; ba_oe_n[0] = 1'b1; a_ext[0] = 8'h4E;
        settle(2);
        ab_ld[0] = 1'b1;
        settle(5);
        m_ab[0] = 8'h4E;
        a_ext[0] = 8'hB1;
        settle(6);
        expect_now("R7 held strobe no reload");
        ab_ld[0] = 1'b0;
        settle(4);

        // R11: both enabled live keep the last value
        ab_sel[0] = 1'b0; ba_sel[0] = 1'b0; ab_oe[0] = 1'b1; a_ext[0] = 8'h6D;
        settle(3);
        hold[0] = 8'h6D;
        ba_oe_n[0] = 1'b0;
        settle(3);
        expect_now("R11 live loop holds");
        a_ext[0] = 8'h12; b_ext[0] = 8'hEE;
        settle(3);
        expect_now("R11 outside change ignored");

        done = 1;
        settle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule